// File: doc/BRIEF.md
# Transmit Timestamp Return Path

This block reports when outgoing frames actually leave. The client submits one command per frame as it hands the frame over. The command holds a 2-bit operation code and a 16-bit tag, and it waits in a small first-in first-out queue. When the frame's start of frame later passes the departure point, the block takes the oldest queued command and samples the system time of day. For one-step and two-step frames it adds a fixed latency correction, so the value refers to a common reference plane. It then returns the corrected timestamp and the tag, qualified by a one-cycle valid strobe.

The returned value is formatted by clock mode. In ordinary-clock mode it is an 80-bit time of day, with seconds in bits 79:32 and nanoseconds in bits 31:0. In transparent-clock mode it is a 64-bit time in the low bits, with the top 16 bits cleared. Two sticky flags record a command pushed into a full queue and a departure seen while the queue was empty.

Top module: `ptp_ts_return`

## Requirements
- R1: The tag presented with a returned timestamp equals the tag submitted with that frame's command, bit for bit.
- R2: In ordinary-clock mode (tc_mode = 0), the returned nanosecond field (bits 31:0) is the sampled nanoseconds plus lat_adj. The seconds field (bits 79:32) equals the sampled seconds when that sum is below 1,000,000,000.
- R3: In ordinary-clock mode, when the nanosecond sum is 1,000,000,000 or more, the block subtracts 1,000,000,000 from the nanoseconds and adds one to the seconds. An exact sum of 1,000,000,000 therefore yields 0 ns.
- R4: In transparent-clock mode (tc_mode = 1), the returned value is tod[63:0] plus lat_adj as a 64-bit sum in bits 63:0, and bits 79:64 are zero.
- R5: Operation codes 2'b01 (one-step) and 2'b10 (two-step) produce a timestamp. Codes 2'b00 (no operation) and 2'b11 (reserved) produce no valid strobe, but they still consume their queue entry.
- R6: The queue holds DEPTH (default 8) commands, and commands are matched to departures strictly in submission order.
- R7: A command submitted while the queue is full is dropped, and err_wr_full is set. The flag stays set until reset.
- R8: A departure strobe while the queue is empty produces no timestamp and sets err_rd_empty. The flag stays set until reset. A command pushed in the same cycle is not yet visible to that departure.
- R9: ts_valid is high for exactly one cycle: the cycle after the clock edge that samples sof. The tag and value in that cycle come from the time sampled at that edge.
- R10: After reset, ts_valid, err_wr_full and err_rd_empty are low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command submission strobe, one per frame |
| cmd_op | input | 2 | Operation: 00 none, 01 one-step, 10 two-step, 11 reserved |
| cmd_tag | input | 16 | Client tag for the frame |
| sof | input | 1 | Start of frame at the departure point |
| tod | input | 80 | System time: seconds 79:32, nanoseconds 31:0 |
| tc_mode | input | 1 | 1 selects transparent-clock formatting |
| lat_adj | input | 11 | Latency correction in nanoseconds |
| ts_valid | output | 1 | One-cycle strobe qualifying tag and value |
| ts_tag | output | 16 | Returned tag |
| ts_value | output | 80 | Corrected timestamp |
| err_wr_full | output | 1 | Sticky: command written into a full queue |
| err_rd_empty | output | 1 | Sticky: departure seen with an empty queue |

## Verification
The hardest state to reach is a full queue that is still ordered correctly after a rejected write. The bench gets there by submitting nine commands back to back with no departures. It then drains the queue with eight departures and checks that the tags return in submission order and that the ninth tag never appears. A further departure then hits the empty queue. The seconds carry is driven at its exact boundary: a sum of exactly one billion nanoseconds must return zero nanoseconds with the seconds incremented.

// File: rtl/ptp_ts_return.sv
module ptp_ts_return #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 16,
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter int TC_W  = 64,
  parameter int LAT_W = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [TAG_W-1:0]       cmd_tag,
  input  logic                   sof,
  input  logic [SEC_W+NS_W-1:0]  tod,
  input  logic                   tc_mode,
  input  logic [LAT_W-1:0]       lat_adj,
  output logic                   ts_valid,
  output logic [TAG_W-1:0]       ts_tag,
  output logic [SEC_W+NS_W-1:0]  ts_value,
  output logic                   err_wr_full,
  output logic                   err_rd_empty
);
  localparam int AW   = $clog2(DEPTH);
  localparam int TS_W = SEC_W + NS_W;
  localparam logic [NS_W:0] NS_PER_SEC = (NS_W+1)'(1_000_000_000);

  logic [1:0]       op_mem  [DEPTH];
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr;

  wire full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  wire empty = (wr_ptr == rd_ptr);
  wire push  = cmd_valid && !full;
  wire pop   = sof && !empty;

  wire [1:0]       head_op  = op_mem[rd_ptr[AW-1:0]];
  wire [TAG_W-1:0] head_tag = tag_mem[rd_ptr[AW-1:0]];
  wire             report   = pop && (head_op == 2'b01 || head_op == 2'b10);

  wire [NS_W:0]  ns_sum  = {1'b0, tod[NS_W-1:0]} + (NS_W+1)'(lat_adj);
  wire [NS_W:0]  ns_wrap = ns_sum - NS_PER_SEC;
  wire           carry   = (ns_sum >= NS_PER_SEC);
  wire [SEC_W-1:0] sec_in = tod[TS_W-1:NS_W];
  wire [TS_W-1:0] oc_val = carry ? {sec_in + SEC_W'(1), ns_wrap[NS_W-1:0]}
                                 : {sec_in, ns_sum[NS_W-1:0]};
  wire [TC_W-1:0] tc_sum = tod[TC_W-1:0] + TC_W'(lat_adj);
  wire [TS_W-1:0] tc_val = {{(TS_W-TC_W){1'b0}}, tc_sum};

  always_ff @(posedge clk) begin
    if (push) begin
      op_mem[wr_ptr[AW-1:0]]  <= cmd_op;
      tag_mem[wr_ptr[AW-1:0]] <= cmd_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      ts_valid     <= 1'b0;
      ts_tag       <= '0;
      ts_value     <= '0;
      err_wr_full  <= 1'b0;
      err_rd_empty <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (cmd_valid && full) err_wr_full  <= 1'b1;
      if (sof && empty)      err_rd_empty <= 1'b1;
      ts_valid <= report;
      if (report) begin
        ts_tag   <= head_tag;
        ts_value <= tc_mode ? tc_val : oc_val;
      end
    end
  end

  wire [AW:0] level = wr_ptr - rd_ptr;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
  p_valid_after_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |-> $past(sof));
  p_empty_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && empty) |=> (!ts_valid && err_rd_empty));
  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr_full |=> err_wr_full);
  p_empty_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_rd_empty |=> err_rd_empty);
  p_tc_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && $past(tc_mode)) |-> (ts_value[TS_W-1:TC_W] == '0));
  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && !$past(tc_mode) && ($past(tod[NS_W-1:0]) < NS_PER_SEC[NS_W-1:0]))
      |-> ({1'b0, ts_value[NS_W-1:0]} < NS_PER_SEC));
endmodule

// File: tb/ptp_ts_return_tb_top.sv
module ptp_ts_return_tb_top;
  localparam int VW = 2 + 16 + 48 + 32 + 1 + 11;
  localparam int NV = 7;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd2, 16'hA5A5, 48'd100,             32'd500,         1'b0, 11'd90},
    {2'd1, 16'h1234, 48'd7,               32'd999_999_990, 1'b0, 11'd20},
    {2'd1, 16'h0001, 48'd55,              32'd999_999_910, 1'b0, 11'd90},
    {2'd2, 16'hBEEF, 48'hFFFF_0000_0001,  32'd1000,        1'b1, 11'd5},
    {2'd0, 16'h0BAD, 48'd3,               32'd3,           1'b0, 11'd3},
    {2'd3, 16'h0C0D, 48'd4,               32'd4,           1'b0, 11'd4},
    {2'd2, 16'hFFFF, 48'h1234_0000_0000,  32'hFFFF_FFFF,   1'b1, 11'd2047}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [15:0] cmd_tag = 0;
  logic        sof = 0;
  logic [79:0] tod = 0;
  logic        tc_mode = 0;
  logic [10:0] lat_adj = 0;
  logic        ts_valid;
  logic [15:0] ts_tag;
  logic [79:0] ts_value;
  logic        err_wr_full, err_rd_empty;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  ptp_ts_return dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tag(cmd_tag), .sof(sof), .tod(tod), .tc_mode(tc_mode),
    .lat_adj(lat_adj), .ts_valid(ts_valid), .ts_tag(ts_tag),
    .ts_value(ts_value), .err_wr_full(err_wr_full), .err_rd_empty(err_rd_empty));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] model(input logic [47:0] s, input logic [31:0] n,
                                        input logic tc, input logic [10:0] l);
    logic [63:0] t;
    if (tc) begin
      t = {s[31:0], n} + {53'd0, l};
      return {16'd0, t};
    end
    t = {32'd0, n} + {53'd0, l};
    if (t >= 64'd1_000_000_000) return {s + 48'd1, 32'(t - 64'd1_000_000_000)};
    return {s, t[31:0]};
  endfunction

  task automatic submit(input logic [1:0] op, input logic [15:0] tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_tag = tag;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic depart(input logic [79:0] t);
    @(negedge clk);
    sof = 1; tod = t;
    @(negedge clk);
    sof = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ts_valid && !err_wr_full && !err_rd_empty, "R10 reset outputs", {77'd0, ts_valid, err_wr_full, err_rd_empty}, 80'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [15:0] tg; logic [47:0] s; logic [31:0] n; logic tc; logic [10:0] l;
      bit want;
      {op, tg, s, n, tc, l} = VEC[i];
      want = (op == 2'd1) || (op == 2'd2);
      tc_mode = tc; lat_adj = l;
      submit(op, tg);
      depart({s, n});
      chk(ts_valid == want, "R5 strobe per op code", {79'd0, ts_valid}, {79'd0, want});
      if (want) begin
        chk(ts_tag == tg, "R1 tag returned", {64'd0, ts_tag}, {64'd0, tg});
        chk(ts_value == model(s, n, tc, l), tc ? "R4 transparent value" : "R2 R3 ordinary value",
            ts_value, model(s, n, tc, l));
      end
      @(negedge clk);
      chk(!ts_valid, "R9 single-cycle strobe", {79'd0, ts_valid}, 80'd0);
    end
    chk(!err_rd_empty && !err_wr_full, "R5 nop entries consumed, no errors", {78'd0, err_wr_full, err_rd_empty}, 80'd0);

    tc_mode = 0; lat_adj = 11'd0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      cmd_valid = 1; cmd_op = 2'd2; cmd_tag = 16'h7000 + 16'(k);
    end
    @(negedge clk);
    cmd_valid = 0;
    chk(err_wr_full, "R7 write to full queue flagged", {79'd0, err_wr_full}, 80'd1);
    for (int k = 0; k < 8; k++) begin
      depart({48'd9, 32'(k)});
      chk(ts_valid && ts_tag == 16'h7000 + 16'(k), "R6 submission order",
          {63'd0, ts_valid, ts_tag}, {63'd0, 1'b1, 16'h7000 + 16'(k)});
    end
    chk(!err_rd_empty, "R6 eight entries held", {79'd0, err_rd_empty}, 80'd0);
    depart({48'd9, 32'd9});
    chk(!ts_valid, "R8 empty departure silent", {79'd0, ts_valid}, 80'd0);
    chk(err_rd_empty, "R8 empty departure flagged", {79'd0, err_rd_empty}, 80'd1);
    @(negedge clk);
    chk(err_wr_full && err_rd_empty, "R7 R8 flags sticky", {78'd0, err_wr_full, err_rd_empty}, 80'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule